// File: doc/BRIEF.md
# Postponable SDRAM Refresh Scheduler

This block decides when the memory controller must issue an AUTO REFRESH command. An interval timer adds one refresh to a count of owed refreshes once per average refresh interval, which is the 64 ms retention period divided across 4096 rows, about 15.6 µs. The block raises a request whenever something is owed. The command arbiter answers that request with a grant, and each accepted grant pays back one refresh.

While the controller reports itself busy, the request is held back, so refreshes pile up as debt and are later paid back in a burst. The debt never grows beyond eight. Once it reaches a configurable threshold, the request ignores the busy hint. At eight, an urgent flag tells the arbiter that no more postponement is possible. That keeps the gap between two refreshes within eight average intervals.

Every accepted grant, and every exit from self refresh, starts a spacing timer that covers the minimum refresh cycle time. The next refresh cannot be requested before that timer runs out. Both the interval and the spacing are given in picoseconds and converted to clock cycles by rounding up.

Top module: `sdram_refresh_sched`

## Requirements
- R1: After reset the owed count is 0 and both the request and the urgent flag are low.
- R2: The owed count rises by one on every tick of the interval timer. The interval timer period is TICK_CYC clock cycles, where TICK_CYC is REFI_PS divided by CLK_PS and rounded up (3900 cycles with the default values). The first tick takes effect at clock edge TICK_CYC after reset is released.
- R3: The owed count saturates at DEBT_MAX (8). A tick that arrives while the count is at DEBT_MAX leaves it at DEBT_MAX.
- R4: While the owed count is below DEFER_LIM (6) and busy is high, the request is low. When busy is low, the spacing window has elapsed and the count is above zero, the request is high.
- R5: When the owed count is at or above DEFER_LIM and the spacing window has elapsed, the request is high whatever the value of busy. The urgent flag is high exactly when the count equals DEBT_MAX.
- R6: A grant is accepted on a clock edge where both the request and the grant are high. After an accepted grant, the request stays low for the next GAP_CYC-1 cycles. GAP_CYC is TRFC_PS divided by CLK_PS and rounded up (20 cycles by default). Two accepted grants are therefore at least GAP_CYC cycles apart.
- R7: Each accepted grant lowers the owed count by exactly one. A grant given while the request is low has no effect on the count.
- R8: A one-cycle self-refresh exit pulse holds the request low for GAP_CYC-1 cycles after the edge on which the pulse is sampled.
- R9: While the owed count is 0 the request is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| busy_i | input | 1 | Controller busy hint; asks the block to defer refreshes |
| grant_i | input | 1 | Arbiter grant; the refresh is issued on an edge where the request is also high |
| sr_exit_i | input | 1 | One-cycle pulse marking the exit from self refresh |
| ref_req_o | output | 1 | Refresh request to the arbiter |
| ref_urgent_o | output | 1 | High when the debt is full and no further deferral is allowed |
| owed_o | output | CW | Number of refreshes currently owed |

## Verification
Several properties are checked on every cycle. The owed count never exceeds its cap. No request appears inside a spacing window, whether that window was opened by a grant or by a self-refresh exit. A busy hint below the threshold always suppresses the request, and a threshold-level debt always forces it. Each tick and each accepted grant moves the count by exactly one. The exact tick period, the point where saturation holds against a ninth tick, the spacing between grants in a full eight-deep catch-up burst, and the release of the request after a self-refresh exit can only be shown by the directed scenarios, which count clock edges from reset.

// File: rtl/sref_pkg.sv
`timescale 1ns/1ps
// Package for the refresh scheduler.
// Holds the rounding-up conversion from picoseconds to clock cycles.
// Assumes that both arguments are positive.
package sref_pkg;
    // Divides a by b and rounds the result up.
    function automatic int ceil_div(longint a, longint b);
        return int'((a + b - 1) / b);
    endfunction
endpackage

// File: rtl/sref_interval_timer.sv
`timescale 1ns/1ps
// Free-running interval timer.
// Produces a one-cycle tick once every TICK_CYC clock cycles.
// The first tick appears TICK_CYC-1 edges after reset, so the state it drives
// changes on edge TICK_CYC. Assumes TICK_CYC >= 2.
module sref_interval_timer #(
    parameter int TICK_CYC = 3900
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int W = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
    localparam logic [W-1:0] RELOAD = W'(TICK_CYC - 1);

    logic [W-1:0] cnt;

    // Count down to zero, then reload.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= RELOAD;
        else if (cnt == '0) cnt <= RELOAD;
        else                cnt <= cnt - 1'b1;
    end

    assign tick_o = (cnt == '0);
endmodule

// File: rtl/sref_gap_timer.sv
`timescale 1ns/1ps
// Spacing timer for the minimum refresh cycle time.
// A start pulse blocks ok_o for the next GAP_CYC-1 cycles.
// After reset the timer is already expired. Assumes GAP_CYC >= 1.
module sref_gap_timer #(
    parameter int GAP_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic ok_o
);
    localparam int W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
    localparam logic [W-1:0] LOAD = W'(GAP_CYC - 1);

    logic [W-1:0] cnt;

    // Load on start, otherwise run down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start_i)    cnt <= LOAD;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign ok_o = (cnt == '0);
endmodule

// File: rtl/sref_debt_counter.sv
`timescale 1ns/1ps
// Counter of owed refreshes.
// Counts up on inc_i and down on dec_i, saturating at DEBT_MAX and at zero.
// When both inputs are high in the same cycle, the count is unchanged.
module sref_debt_counter #(
    parameter int DEBT_MAX = 8,
    parameter int CW       = $clog2(DEBT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          dec_i,
    output logic [CW-1:0] owed_o
);
    localparam logic [CW-1:0] MAXV = CW'(DEBT_MAX);

    // Apply one tick and/or one accepted grant per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed_o <= '0;
        end else begin
            unique case ({inc_i, dec_i})
                2'b10:   if (owed_o != MAXV) owed_o <= owed_o + 1'b1;
                2'b01:   if (owed_o != '0)   owed_o <= owed_o - 1'b1;
                default: owed_o <= owed_o;
            endcase
        end
    end
endmodule

// File: rtl/sdram_refresh_sched.sv
`timescale 1ns/1ps
// Postponable refresh scheduler (top level).
// Tracks the number of owed AUTO REFRESH commands and requests them from the
// command arbiter. Below DEFER_LIM the busy hint can defer them; at or above
// DEFER_LIM the request ignores busy. Grants and self-refresh exits are spaced
// by GAP_CYC cycles.
// Assumes the arbiter issues the command on the edge where ref_req_o and
// grant_i are both high, and that sr_exit_i is a one-cycle pulse.
module sdram_refresh_sched #(
    parameter int CLK_PS    = 4000,
    parameter int REFI_PS   = 15_600_000,
    parameter int TRFC_PS   = 80_000,
    parameter int DEBT_MAX  = 8,
    parameter int DEFER_LIM = 6,
    parameter int CW        = $clog2(DEBT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy_i,
    input  logic          grant_i,
    input  logic          sr_exit_i,
    output logic          ref_req_o,
    output logic          ref_urgent_o,
    output logic [CW-1:0] owed_o
);
    import sref_pkg::*;

    localparam int TICK_CYC = ceil_div(longint'(REFI_PS), longint'(CLK_PS));
    localparam int GAP_CYC  = ceil_div(longint'(TRFC_PS), longint'(CLK_PS));
    localparam logic [CW-1:0] LIMV = CW'(DEFER_LIM);
    localparam logic [CW-1:0] MAXV = CW'(DEBT_MAX);

    logic tick_w;
    logic gap_ok;
    logic accept;

    sref_interval_timer #(.TICK_CYC(TICK_CYC)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick_w)
    );

    sref_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (accept | sr_exit_i),
        .ok_o    (gap_ok)
    );

    sref_debt_counter #(.DEBT_MAX(DEBT_MAX), .CW(CW)) u_debt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (tick_w),
        .dec_i  (accept),
        .owed_o (owed_o)
    );

    // Request when something is owed, spacing allows it, and busy does not defer it.
    always_comb begin
        ref_req_o = gap_ok && (owed_o != '0) && (!busy_i || owed_o >= LIMV);
    end

    assign accept       = ref_req_o & grant_i;
    assign ref_urgent_o = (owed_o == MAXV);
endmodule

// File: rtl/sref_sched_checker.sv
`timescale 1ns/1ps
// Assertion checker bound to sdram_refresh_sched.
// Keeps its own count of the cycles since the last spacing event.
module sref_sched_checker #(
    parameter int DEBT_MAX  = 8,
    parameter int DEFER_LIM = 6,
    parameter int GAP_CYC   = 20,
    parameter int CW        = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          grant,
    input logic          sr_exit,
    input logic          req,
    input logic          urgent,
    input logic [CW-1:0] owed,
    input logic          tick
);
    int since;

    // Cycles since the last accepted grant or self-refresh exit, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                        since <= GAP_CYC - 1;
        else if ((req && grant) || sr_exit) since <= 0;
        else if (since < GAP_CYC - 1)      since <= since + 1;
    end

    p_reset_r1: assert property (@(posedge clk) !rst_n |=> (owed == '0 && !req));
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n) int'(owed) <= DEBT_MAX);
    p_tick_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(req && grant) && int'(owed) < DEBT_MAX) |=> int'(owed) == int'($past(owed)) + 1);
    p_busy_defer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && int'(owed) < DEFER_LIM) |-> !req);
    p_forced_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(owed) >= DEFER_LIM && since >= GAP_CYC - 1) |-> req);
    p_urgent_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        urgent |-> !busy || req || since < GAP_CYC - 1);
    p_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> since >= GAP_CYC - 1);
    p_grant_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && grant && !tick) |=> int'(owed) == int'($past(owed)) - 1);
    p_empty_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (owed == '0) |-> !req);
endmodule

bind sdram_refresh_sched sref_sched_checker #(
    .DEBT_MAX  (DEBT_MAX),
    .DEFER_LIM (DEFER_LIM),
    .GAP_CYC   (GAP_CYC),
    .CW        (CW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy_i),
    .grant   (grant_i),
    .sr_exit (sr_exit_i),
    .req     (ref_req_o),
    .urgent  (ref_urgent_o),
    .owed    (owed_o),
    .tick    (tick_w)
);

// File: tb/sdram_refresh_sched_test.sv
`timescale 1ns/1ps
// Directed bench for sdram_refresh_sched with default parameters:
// TICK = 3900 cycles, GAP = 20 cycles, DEFER_LIM = 6, DEBT_MAX = 8.
module sdram_refresh_sched_test;
    localparam int TICK = 3900;
    localparam int GAP  = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busy = 1'b0;
    logic       grant = 1'b0;
    logic       sr_exit = 1'b0;
    logic       req;
    logic       urgent;
    logic [3:0] owed;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    sdram_refresh_sched uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy_i       (busy),
        .grant_i      (grant),
        .sr_exit_i    (sr_exit),
        .ref_req_o    (req),
        .ref_urgent_o (urgent),
        .owed_o       (owed)
    );

    always #2 clk = ~clk;

    // Number of clock edges since reset was released.
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic wait_cyc(int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 owed", int'(owed), 0);
        chk("R1 req", int'(req), 0);
        chk("R1 urgent", int'(urgent), 0);
    endtask

    task automatic t_tick;
        wait_cyc(TICK - 1);
        chk("R2 owed before first tick", int'(owed), 0);
        chk("R9 req while empty", int'(req), 0);
        @(negedge clk);
        chk("R2 owed after first tick", int'(owed), 1);
        chk("R4 req when idle", int'(req), 1);
        busy = 1'b1;
        #1;
        chk("R4 req deferred by busy", int'(req), 0);
    endtask

    task automatic t_defer;
        wait_cyc(5 * TICK);
        chk("R2 owed after five ticks", int'(owed), 5);
        chk("R4 req deferred at five", int'(req), 0);
        wait_cyc(6 * TICK);
        chk("R5 req forced at limit", int'(req), 1);
        chk("R5 urgent below max", int'(urgent), 0);
        wait_cyc(8 * TICK);
        chk("R3 owed at max", int'(owed), 8);
        chk("R5 urgent at max", int'(urgent), 1);
        wait_cyc(9 * TICK);
        chk("R3 owed saturates", int'(owed), 8);
    endtask

    task automatic t_drain;
        int acc;
        int last;
        wait_cyc(9 * TICK + 1);
        busy  = 1'b0;
        grant = 1'b1;
        #1;
        chk("R6 req before burst", int'(req), 1);
        acc  = 1;
        last = cyc;
        @(negedge clk);
        chk("R7 one decrement", int'(owed), 7);
        chk("R6 req low after grant", int'(req), 0);
        for (int i = 0; i < 170; i++) begin
            if (req) begin
                acc++;
                chk("R6 grant spacing", cyc - last, GAP);
                last = cyc;
            end
            @(negedge clk);
        end
        chk("R7 grants accepted", acc, 8);
        chk("R7 owed drained", int'(owed), 0);
        chk("R9 req after drain", int'(req), 0);
        repeat (5) @(negedge clk);
        chk("R7 grant ignored when idle", int'(owed), 0);
        grant = 1'b0;
    endtask

    task automatic t_srexit;
        wait_cyc(10 * TICK);
        chk("R2 owed after later tick", int'(owed), 1);
        sr_exit = 1'b1;
        @(negedge clk);
        sr_exit = 1'b0;
        chk("R8 req blocked after exit", int'(req), 0);
        wait_cyc(10 * TICK + GAP - 1);
        chk("R8 req still blocked", int'(req), 0);
        @(negedge clk);
        chk("R8 req released", int'(req), 1);
        grant = 1'b1;
        @(negedge clk);
        grant = 1'b0;
        chk("R7 owed after grant", int'(owed), 0);
    endtask

    initial begin
        t_reset();
        t_tick();
        t_defer();
        t_drain();
        t_srexit();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 100_000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule